// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Unit

A purely combinational integer unit for the execute stage of a small RISC pipeline. It takes two operands and a three-bit operation code. It returns one result word and one overflow-exception flag. Six operations share a single adder:

- add and subtract, each in a trapping form and a non-trapping form;
- signed set-less-than;
- unsigned set-less-than.

Subtraction adds the inverted second operand with a carry-in of one. This is the usual two's complement negation: invert every bit, then add one.

The overflow flag goes to the exception logic of the pipeline. It can be high only for the trapping add and the trapping subtract. The non-trapping forms wrap silently. The two compares reuse the subtraction:

- The signed compare reads the sign of the true difference. This is the raw sign bit XOR the overflow, so it stays correct when the subtraction wraps.
- The unsigned compare reads the borrow out of the top bit.

Top module: `int_addsub_cmp`

## Requirements
- R1: For op_i = 0 (trapping add) and op_i = 1 (non-trapping add), result_o equals a_i + b_i modulo 2^WIDTH.
- R2: For op_i = 2 (trapping subtract) and op_i = 3 (non-trapping subtract), result_o equals a_i plus the bitwise inverse of b_i plus one, modulo 2^WIDTH.
- R3: For op_i = 0, ovf_o is 1 exactly in two cases: both operands have bit WIDTH-1 clear and the result has it set, or both operands have it set and the result has it clear.
- R4: For op_i = 2, ovf_o is 1 exactly in two cases: a_i is non-negative, b_i is negative and the result is negative; or a_i is negative, b_i is non-negative and the result is non-negative. Negative means bit WIDTH-1 is 1, and zero counts as non-negative.
- R5: A trapping add of operands with opposite signs never sets ovf_o. A trapping subtract of operands with the same sign never sets ovf_o.
- R6: For op_i = 1 and op_i = 3, ovf_o is 0 for every operand pair, including pairs whose signed result wraps.
- R7: For op_i = 4 (signed set-less-than), result_o is 1 when a_i < b_i as two's complement values and 0 otherwise. This holds even when the internal subtraction overflows. For example, all-ones against one gives 1.
- R8: For op_i = 5 (unsigned set-less-than), result_o is 1 when a_i < b_i as unsigned values and 0 otherwise. For example, all-ones against one gives 0.
- R9: For op_i = 4 and op_i = 5, bits WIDTH-1 down to 1 of result_o are 0 and ovf_o is 0.
- R10: For the unused codes op_i = 6 and op_i = 7, result_o is 0 and ovf_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH (32) | First operand |
| b_i | input | WIDTH (32) | Second operand (subtrahend for subtract and compare) |
| op_i | input | 3 | Operation code, encoded as given in the requirements |
| result_o | output | WIDTH (32) | Sum, difference, or compare result of 0 or 1 |
| ovf_o | output | 1 | Overflow exception, raised by the trapping forms only |

## Verification
The unit has no registers, so both result_o and ovf_o settle in the same cycle the operands and the operation code are applied. The latency is zero cycles.

The driver changes the inputs just after a rising edge and queues the expected pair for that vector. The monitor pops the queue and compares on the following falling edge. Every vector is therefore checked half a period after it is applied and before the next one arrives.

The expected values come from wide signed and unsigned integer arithmetic in the bench, not from carries. The directed corners are:
- wrap at both ends of the signed range;
- equal operands;
- the all-ones-versus-one compare pair.

A long pseudo-random run then covers all eight codes.

// File: rtl/int_arith_pkg.sv
package int_arith_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_TRAP = 3'd0,
    OP_ADD_WRAP = 3'd1,
    OP_SUB_TRAP = 3'd2,
    OP_SUB_WRAP = 3'd3,
    OP_SLT_S    = 3'd4,
    OP_SLT_U    = 3'd5,
    OP_RSVD6    = 3'd6,
    OP_RSVD7    = 3'd7
  } arith_op_e;
endpackage

// File: rtl/int_operand_prep.sv
module int_operand_prep
  import int_arith_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  arith_op_e         op_i,
  input  logic [WIDTH-1:0]  b_i,
  output logic [WIDTH-1:0]  b_eff_o,
  output logic              cin_o,
  output logic              is_sub_o
);
  logic sub_like;

  always_comb begin
    unique case (op_i)
      OP_SUB_TRAP, OP_SUB_WRAP, OP_SLT_S, OP_SLT_U: sub_like = 1'b1;
      default:                                      sub_like = 1'b0;
    endcase
  end

  // negate b as invert-plus-one: the one enters as carry-in
  assign b_eff_o  = sub_like ? ~b_i : b_i;
  assign cin_o    = sub_like;
  assign is_sub_o = sub_like;
endmodule

// File: rtl/int_adder.sv
module int_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             c_msb_o
);
  localparam int unsigned LOW_W = WIDTH - 1;

  logic [WIDTH:0] full;
  logic [LOW_W:0] low;

  assign full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  // carry into the top bit, used for overflow
  assign low  = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_i[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin_i};

  assign sum_o   = full[WIDTH-1:0];
  assign cout_o  = full[WIDTH];
  assign c_msb_o = low[LOW_W];
endmodule

// File: rtl/int_flags.sv
module int_flags #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] sum_i,
  input  logic             cout_i,
  input  logic             c_msb_i,
  output logic             ovf_raw_o,
  output logic             lt_s_o,
  output logic             lt_u_o
);
  assign ovf_raw_o = c_msb_i ^ cout_i;
  // sign of the true difference, valid across wrap
  assign lt_s_o    = sum_i[WIDTH-1] ^ ovf_raw_o;
  // no carry out of a + ~b + 1 means a borrow: a < b unsigned
  assign lt_u_o    = ~cout_i;
endmodule

// File: rtl/int_addsub_cmp.sv
module int_addsub_cmp
  import int_arith_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             ovf_o
);
  arith_op_e        op;
  logic [WIDTH-1:0] b_eff, sum;
  logic             cin, is_sub, cout, c_msb;
  logic             ovf_raw, lt_s, lt_u;

  assign op = arith_op_e'(op_i);

  int_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .op_i     (op),
    .b_i      (b_i),
    .b_eff_o  (b_eff),
    .cin_o    (cin),
    .is_sub_o (is_sub)
  );

  int_adder #(.WIDTH(WIDTH)) u_add (
    .a_i     (a_i),
    .b_i     (b_eff),
    .cin_i   (cin),
    .sum_o   (sum),
    .cout_o  (cout),
    .c_msb_o (c_msb)
  );

  int_flags #(.WIDTH(WIDTH)) u_flags (
    .sum_i     (sum),
    .cout_i    (cout),
    .c_msb_i   (c_msb),
    .ovf_raw_o (ovf_raw),
    .lt_s_o    (lt_s),
    .lt_u_o    (lt_u)
  );

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    unique case (op)
      OP_ADD_TRAP: begin result_o = sum; ovf_o = ovf_raw & ~is_sub; end
      OP_ADD_WRAP: result_o = sum;
      OP_SUB_TRAP: begin result_o = sum; ovf_o = ovf_raw & is_sub; end
      OP_SUB_WRAP: result_o = sum;
      OP_SLT_S:    result_o = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLT_U:    result_o = {{(WIDTH-1){1'b0}}, lt_u};
      default: begin result_o = '0; ovf_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/int_addsub_cmp_chk.sv
module int_addsub_cmp_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    if (op_i == 3'd0 || op_i == 3'd1)
      p_add_sum_r1: assert (result_o == a_i + b_i);
    if (op_i == 3'd2 || op_i == 3'd3)
      p_sub_diff_r2: assert (result_o == a_i - b_i);
    if (op_i == 3'd0 && a_i[MSB] != b_i[MSB])
      p_opp_sign_add_r5: assert (!ovf_o);
    if (op_i == 3'd2 && a_i[MSB] == b_i[MSB])
      p_same_sign_sub_r5: assert (!ovf_o);
    if (op_i == 3'd1 || op_i == 3'd3)
      p_no_overflow_r6: assert (!ovf_o);
    if (op_i == 3'd4)
      p_slt_signed_r7: assert (result_o[0] == ($signed(a_i) < $signed(b_i)));
    if (op_i == 3'd5)
      p_slt_unsigned_r8: assert (result_o[0] == (a_i < b_i));
    if (op_i == 3'd4 || op_i == 3'd5)
      p_slt_bool_r9: assert (result_o[MSB:1] == '0 && !ovf_o);
    if (op_i[2:1] == 2'b11)
      p_unused_zero_r10: assert (result_o == '0 && !ovf_o);
  end
endmodule

bind int_addsub_cmp int_addsub_cmp_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_int_addsub_cmp.sv
module sim_int_addsub_cmp;
  localparam int unsigned WIDTH    = 32;
  localparam time         CLK_PER  = 10ns;
  localparam int unsigned WDOG_CYC = 20000;

  typedef struct {
    logic [WIDTH-1:0] a;
    logic [WIDTH-1:0] b;
    logic [2:0]       op;
    logic [WIDTH-1:0] exp_r;
    logic             exp_v;
    string            tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [WIDTH-1:0] a = '0, b = '0;
  logic [2:0]       op = '0;
  logic [WIDTH-1:0] result;
  logic             ovf;

  item_t       sb_q[$];
  int unsigned n_vec = 0, n_fail = 0;
  logic [31:0] rng = 32'h1234_5678;
  bit          done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  int_addsub_cmp #(.WIDTH(WIDTH)) u0 (
    .a_i(a), .b_i(b), .op_i(op), .result_o(result), .ovf_o(ovf)
  );

  function automatic void model(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                                input logic [2:0] o,
                                output logic [WIDTH-1:0] r, output logic v);
    longint sx, sy, s;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    r = '0; v = 1'b0;
    case (o)
      3'd0, 3'd1: begin
        r = x + y; s = sx + sy;
        v = (o == 3'd0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      3'd2, 3'd3: begin
        r = x - y; s = sx - sy;
        v = (o == 3'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      3'd4: r = (sx < sy) ? 1 : 0;
      3'd5: r = (x < y) ? 1 : 0;
      default: r = '0;
    endcase
  endfunction

  task automatic apply(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                       input logic [2:0] o, input string tag);
    item_t it;
    @(posedge clk);
    a <= x; b <= y; op <= o;
    it.a = x; it.b = y; it.op = o; it.tag = tag;
    model(x, y, o, it.exp_r, it.exp_v);
    sb_q.push_back(it);
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // monitor: results are due in the same cycle, sampled on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_vec++;
        if (result !== it.exp_r || ovf !== it.exp_v) begin
          n_fail++;
          $display("FAIL %s op=%0d a=%h b=%h: got r=%h v=%b, expected r=%h v=%b",
                   it.tag, it.op, it.a, it.b, result, ovf, it.exp_r, it.exp_v);
        end
      end
    end
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state after reset: zero operands, add code
    apply(32'h0, 32'h0, 3'd0, "R1 idle");
    // R1 add forms
    apply(32'd7, 32'd6, 3'd0, "R1");
    apply(32'hFFFF_FFFF, 32'd1, 3'd1, "R1 wrap");
    // R2 subtract forms
    apply(32'd7, 32'd6, 3'd2, "R2");
    apply(32'd6, 32'd7, 3'd3, "R2 neg");
    // R3 trapping add overflow
    apply(32'h7FFF_FFFF, 32'd1, 3'd0, "R3 pos+pos");
    apply(32'h8000_0000, 32'h8000_0000, 3'd0, "R3 neg+neg");
    apply(32'h8000_0000, 32'hFFFF_FFFF, 3'd0, "R3 neg+neg");
    // R4 trapping subtract overflow
    apply(32'h8000_0000, 32'd1, 3'd2, "R4 neg-pos");
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'd2, "R4 pos-neg");
    apply(32'h0, 32'h8000_0000, 3'd2, "R4 zero-min");
    // R5 no overflow across opposite signs / same signs
    apply(32'h7FFF_FFFF, 32'h8000_0000, 3'd0, "R5 add opp");
    apply(32'h8000_0000, 32'hFFFF_FFFF, 3'd2, "R5 sub same");
    // R6 wrapping forms never flag
    apply(32'h7FFF_FFFF, 32'd1, 3'd1, "R6 add");
    apply(32'h8000_0000, 32'd1, 3'd3, "R6 sub");
    // R7 signed compare
    apply(32'hFFFF_FFFF, 32'd1, 3'd4, "R7 -1<1");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 3'd4, "R7 wrap max<min");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 3'd4, "R7 wrap min<max");
    apply(32'd5, 32'd5, 3'd4, "R7 equal");
    // R8 unsigned compare
    apply(32'hFFFF_FFFF, 32'd1, 3'd5, "R8 big<1");
    apply(32'd1, 32'hFFFF_FFFF, 3'd5, "R8 1<big");
    apply(32'd0, 32'd0, 3'd5, "R8 equal");
    // R9 compares never flag, even with overflowing difference
    apply(32'h8000_0000, 32'd1, 3'd4, "R9");
    apply(32'h8000_0000, 32'd1, 3'd5, "R9");
    // R10 unused codes
    apply(32'h1234_5678, 32'h9ABC_DEF0, 3'd6, "R10");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7, "R10");
    // random sweep over every code
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      rng = next_rng(rng); x = rng;
      rng = next_rng(rng); y = rng;
      if (i % 5 == 0) y = x;
      apply(x, y, 3'(i % 8), "R1-sweep");
    end
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule